// File: doc/BRIEF.md
# Synchronized Pipeline Stage Pulse Controller

This block controls one stage of a pipeline whose stages all share a single global clock. Each stage's data register is loaded only when two conditions hold: the stage feeding it has finished its work, and the stage after it has taken the previous result. Both conditions reach this block as asynchronous level signals. The block passes each of them through a flip-flop synchronizer. When it sees both of them high in the same clock cycle, it issues one clock-wide load pulse for the stage register.

After a pulse the block holds off. It raises a combined handshake flag, which serves as an acknowledge to the stage before and a request to the stage after. It then waits until both inputs have fallen again, which is a return-to-zero phase, before it arms itself for the next transfer. A chain of these controllers, one per stage, forms the control of an elastic pipeline that runs on one clock. The timing of each stage is then set by its neighbours' handshakes and not by a fixed schedule.

Top module: `stage_pulse_ctrl`

## Requirements
- R1: While `rstN` is low, `loadPulse`, `upAck` and `downReq` are all low. The controller leaves reset armed, in its search state.
- R2: Suppose one input is already held high and the other rises just before clock edge k. Then `loadPulse` is high for the cycle that follows edge k + SYNC_STAGES (edge k+2 with the default of 2 synchronizer flops), and it is low before that edge.
- R3: With `goIn` low, `doneIn` held high for any length of time produces no pulse.
- R4: With `doneIn` low, `goIn` held high for any length of time produces no pulse.
- R5: Each pulse on `loadPulse` lasts exactly one clock cycle.
- R6: After a pulse, no further pulse occurs while either synchronized input remains high, even when only one of them stays high.
- R7: Once both inputs are low, `upAck` and `downReq` fall SYNC_STAGES + 1 edges after the later input dropped, and the controller is armed again. A later rise of both inputs produces a new pulse with the R2 latency.
- R8: `upAck` and `downReq` rise in the same cycle as the pulse. They are always equal, and they stay high through the whole waiting phase.
- R9: `loadPulse` is never high in two consecutive cycles. Holding both inputs high for a long time yields a single pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global pipeline clock |
| rstN | input | 1 | Asynchronous active-low reset |
| doneIn | input | 1 | Asynchronous: upstream stage has finished processing |
| goIn | input | 1 | Asynchronous: downstream stage has accepted the previous data |
| loadPulse | output | 1 | One-cycle load strobe for this stage's data register |
| upAck | output | 1 | Acknowledge to the upstream stage, high from the pulse until the controller is armed again |
| downReq | output | 1 | Request to the downstream stage, same timing as upAck |

## Verification
Some properties are checked on every cycle. A pulse never lasts more than one cycle. A pulse always follows a cycle in which both synchronized inputs were high. The acknowledge and request match and are high whenever a pulse is. No pulse appears while the handshake flag was high in the previous cycle. Other behaviour depends on stimulus sequences, so only the bench scenarios can show it. These are the exact synchronizer latency, the refusal to fire on a single input held for many cycles, the hold in the waiting state when only one input drops, and the exact edge on which the flag clears and the controller re-arms.

// File: rtl/stage_pulse_pkg.sv
package stage_pulse_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_HOLD   = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic fire;
    logic rearm;
  } ctrlStrobe_t;

endpackage

// File: rtl/stage_pulse_sync.sv
module stage_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_flop
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/stage_pulse_fsm.sv
module stage_pulse_fsm
  import stage_pulse_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        doneSync,
  input  logic        goSync,
  output ctrlStrobe_t strobe
);
  ctrlState_t state, stateNext;
  logic       capture;
  logic       bothLow;

  assign capture = doneSync & goSync;
  assign bothLow = ~doneSync & ~goSync;

  always_comb begin
    stateNext    = state;
    strobe.fire  = 1'b0;
    strobe.rearm = 1'b0;
    unique case (state)
      ST_SEARCH: begin
        if (capture) begin
          strobe.fire = 1'b1;
          stateNext   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (bothLow) begin
          strobe.rearm = 1'b1;
          stateNext    = ST_SEARCH;
        end
      end
      default: stateNext = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= stateNext;
  end
endmodule

// File: rtl/stage_pulse_dp.sv
module stage_pulse_dp
  import stage_pulse_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        pulseQ,
  output logic        handshakeQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ     <= 1'b0;
      handshakeQ <= 1'b0;
    end else begin
      pulseQ <= strobe.fire;
      if (strobe.fire)       handshakeQ <= 1'b1;
      else if (strobe.rearm) handshakeQ <= 1'b0;
    end
  end
endmodule

// File: rtl/stage_pulse_ctrl.sv
module stage_pulse_ctrl
  import stage_pulse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic doneIn,
  input  logic goIn,
  output logic loadPulse,
  output logic upAck,
  output logic downReq
);
  logic        doneSync;
  logic        goSync;
  logic        handshake;
  ctrlStrobe_t strobe;

  stage_pulse_sync #(.STAGES(SYNC_STAGES)) u_syncDone (
    .clk(clk), .rstN(rstN), .asyncIn(doneIn), .syncOut(doneSync)
  );

  stage_pulse_sync #(.STAGES(SYNC_STAGES)) u_syncGo (
    .clk(clk), .rstN(rstN), .asyncIn(goIn), .syncOut(goSync)
  );

  stage_pulse_fsm u_fsm (
    .clk(clk), .rstN(rstN), .doneSync(doneSync), .goSync(goSync), .strobe(strobe)
  );

  stage_pulse_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pulseQ(loadPulse), .handshakeQ(handshake)
  );

  assign upAck   = handshake;
  assign downReq = handshake;
endmodule

// File: rtl/stage_pulse_ctrl_chk.sv
module stage_pulse_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic doneSync,
  input logic goSync,
  input logic loadPulse,
  input logic upAck,
  input logic downReq
);
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_idle_r1: assert (!loadPulse && !upAck && !downReq)
        else $error("reset state not idle");
    end
  end

  p_pulse_needs_both_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadPulse) |-> $past(doneSync && goSync));

  p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse);

  p_no_refire_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(upAck) |-> !loadPulse);

  p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> (upAck && downReq));

  p_ack_req_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    upAck == downReq);
endmodule

bind stage_pulse_ctrl stage_pulse_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .doneSync(doneSync), .goSync(goSync),
  .loadPulse(loadPulse), .upAck(upAck), .downReq(downReq)
);

// File: tb/stage_pulse_ctrl_tb.sv
module stage_pulse_ctrl_tb;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doneIn = 1'b0;
  logic goIn = 1'b0;
  logic loadPulse, upAck, downReq;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  stage_pulse_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .doneIn(doneIn), .goIn(goIn),
    .loadPulse(loadPulse), .upAck(upAck), .downReq(downReq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts pulses over n cycles, sampling at negedges.
  task automatic countPulses(input int n, output int cnt, output int adjacent);
    bit prev = 1'b0;
    cnt = 0; adjacent = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (loadPulse) cnt++;
      if (loadPulse && prev) adjacent++;
      prev = loadPulse;
    end
  endtask

  task automatic idleBoth();
    doneIn = 1'b0; goIn = 1'b0;
    stepN(LAT + 2);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!loadPulse && !upAck && !downReq, "R1 outputs low in reset",
          {loadPulse, upAck, downReq}, 0);
    rstN = 1'b1;
    stepN(2);
    check(!loadPulse && !upAck, "R1 idle after reset", {loadPulse, upAck}, 0);
  endtask

  task automatic testSingleInputs();
    int c, a;
    doneIn = 1'b1;
    countPulses(12, c, a);
    check(c == 0 && !upAck, "R3 done alone no pulse", c, 0);
    idleBoth();
    goIn = 1'b1;
    countPulses(12, c, a);
    check(c == 0 && !upAck, "R4 go alone no pulse", c, 0);
  endtask

  task automatic testLatency();
    // goIn already high from previous scenario; raise doneIn now.
    doneIn = 1'b1;
    stepN(LAT - 1);
    check(!loadPulse, "R2 no pulse before latency", loadPulse, 0);
    stepN(1);
    check(loadPulse == 1'b1, "R2 pulse at latency", loadPulse, 1);
    check(upAck && downReq, "R8 flag rises with pulse", {upAck, downReq}, 3);
    stepN(1);
    check(!loadPulse, "R5 pulse one cycle", loadPulse, 0);
    check(upAck && downReq, "R8 flag held after pulse", {upAck, downReq}, 3);
  endtask

  task automatic testHoldAndRelease();
    int c, a;
    countPulses(15, c, a);
    check(c == 0, "R9 no repeat pulse while both held", c, 0);
    check(upAck == 1'b1, "R6 still waiting with both high", upAck, 1);
    doneIn = 1'b0;
    countPulses(10, c, a);
    check(c == 0 && upAck, "R6 hold while go stays high", upAck, 1);
    goIn = 1'b0;
    stepN(LAT - 1);
    check(upAck == 1'b1, "R7 flag before re-arm edge", upAck, 1);
    stepN(1);
    check(!upAck && !downReq, "R7 flag cleared on re-arm", {upAck, downReq}, 0);
    doneIn = 1'b1; goIn = 1'b1;
    stepN(LAT - 1);
    check(!loadPulse, "R7 new transfer not early", loadPulse, 0);
    stepN(1);
    check(loadPulse == 1'b1, "R7 new pulse after re-arm", loadPulse, 1);
  endtask

  task automatic testLongHold();
    int c, a;
    idleBoth();
    doneIn = 1'b1; goIn = 1'b1;
    countPulses(40, c, a);
    check(c == 1, "R9 one pulse over long hold", c, 1);
    check(a == 0, "R9 no adjacent pulses", a, 0);
    check(upAck == downReq, "R8 ack equals req", upAck, downReq);
    idleBoth();
    check(!upAck, "R7 idle after final release", upAck, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testSingleInputs();
        testLatency();
        testHoldAndRelease();
        testLongHold();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule